// File: doc/BRIEF.md
# Look-Up-Table Style Distributed RAM

This block is a small bit-oriented memory built from 16-word by 1-bit storage cells. Each cell has the same arrangement as a look-up table turned into RAM: writes happen on the rising clock edge when a write enable is high, and reads are combinational. Cells are tiled in two directions. Extra address bits above the low four pick one of several 16-word banks, which makes the memory deeper (32x1 with a 5-bit address, for example). Parallel cells that share an address make it wider (16x2, for example).

There are two read ports. The primary port reads the word at the same address that is used for writing. The secondary port reads an independent address. Each port has a combinational output. Each port also has a registered copy for callers that need a synchronous read. A synchronous reset clears every stored bit and both output registers.

Top module: `distRam`

## Requirements
- R1: While `rst` is high at a rising edge, every stored word and both registered outputs become zero. After reset, every address reads zero on both ports.
- R2: At a rising edge with `wrEn` high and `rst` low, `wrData` is stored at `addr`.
- R3: At a rising edge with `wrEn` low, no stored word changes.
- R4: `rdData` shows the word at `addr` combinationally. It follows an address change with no clock edge.
- R5: While a write to `addr` is pending, `rdData` shows the old word until the rising edge and the new word after it.
- R6: `rdData2` shows the word at `rdAddr2`, independent of `addr`. A write to a different address leaves it unchanged.
- R7: Address bits above bit 3 select the 16-word bank. Two addresses that differ only in those bits are separate words, and at most one bank is written per edge.
- R8: Bit i of `wrData` is stored in, and returned on, bit i of the read data only. Each bit is independent of the others.
- R9: After each rising edge, `rdDataQ` and `rdData2Q` hold the values that `rdData` and `rdData2` had just before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write and register clock |
| rst | input | 1 | Synchronous clear of storage and registers |
| wrEn | input | 1 | Write enable |
| addr | input | ADDR_W | Write address and primary read address |
| wrData | input | DATA_W | Write data |
| rdAddr2 | input | ADDR_W | Secondary read address |
| rdData | output | DATA_W | Combinational read at `addr` |
| rdData2 | output | DATA_W | Combinational read at `rdAddr2` |
| rdDataQ | output | DATA_W | Registered primary read |
| rdData2Q | output | DATA_W | Registered secondary read |

## Verification
A wrong bank decode or a wrong cell write enable corrupts a word. It does not show at once. It shows the first time that word is read back, on either port, combinationally in the same cycle as the read. For this reason the bench keeps a full shadow of the memory and sweeps every address after each scenario. An error in the output register shows one edge after the primary or secondary read value it should have captured.

// File: rtl/distRamPkg.sv
package distRamPkg;
  localparam int CELL_AW = 4;
  localparam int CELL_DEPTH = 1 << CELL_AW;

  typedef struct packed {
    logic wrStrobe;
    logic clearAll;
  } ramStrobes_t;
endpackage

// File: rtl/lutCell16.sv
module lutCell16
  import distRamPkg::*;
(
  input  logic               clk,
  input  logic               clr,
  input  logic               we,
  input  logic               d,
  input  logic [CELL_AW-1:0] wa,
  input  logic [CELL_AW-1:0] ra,
  output logic               qA,
  output logic               qB
);
  logic [CELL_DEPTH-1:0] mem;

  always_ff @(posedge clk) begin
    if (clr) mem <= '0;
    else if (we) mem[wa] <= d;
  end

  assign qA = mem[wa];
  assign qB = mem[ra];

  // R2
  wr_lands_chk: assert property (@(posedge clk) disable iff (clr)
    we |=> mem[$past(wa)] == $past(d));
  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (clr)
    !we |=> $stable(mem));
  // R1
  clear_chk: assert property (@(posedge clk)
    clr |=> mem == '0);
endmodule

// File: rtl/distRamCtrl.sv
module distRamCtrl
  import distRamPkg::*;
(
  input  logic        rst,
  input  logic        wrEn,
  output ramStrobes_t strobes
);
  always_comb begin
    strobes.clearAll = rst;
    strobes.wrStrobe = wrEn && !rst;
  end
endmodule

// File: rtl/distRamDatapath.sv
module distRamDatapath
  import distRamPkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 2
) (
  input  logic              clk,
  input  ramStrobes_t       strobes,
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] rdAddr2,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] rdData2,
  output logic [DATA_W-1:0] rdDataQ,
  output logic [DATA_W-1:0] rdData2Q
);
  localparam int BANKS = 1 << (ADDR_W - CELL_AW);

  logic [BANKS-1:0]  bankWe;
  logic [DATA_W-1:0] bankOutA [BANKS];
  logic [DATA_W-1:0] bankOutB [BANKS];
  logic [ADDR_W-1:0] wrBank;
  logic [ADDR_W-1:0] rdBank2;

  assign wrBank  = addr >> CELL_AW;
  assign rdBank2 = rdAddr2 >> CELL_AW;

  for (genvar b = 0; b < BANKS; b++) begin : gBank
    assign bankWe[b] = strobes.wrStrobe && (wrBank == ADDR_W'(b));
    for (genvar w = 0; w < DATA_W; w++) begin : gBit
      lutCell16 uCell (
        .clk(clk),
        .clr(strobes.clearAll),
        .we (bankWe[b]),
        .d  (wrData[w]),
        .wa (addr[CELL_AW-1:0]),
        .ra (rdAddr2[CELL_AW-1:0]),
        .qA (bankOutA[b][w]),
        .qB (bankOutB[b][w])
      );
    end
  end

  always_comb begin
    rdData  = '0;
    rdData2 = '0;
    for (int b = 0; b < BANKS; b++) begin
      if (wrBank == ADDR_W'(b))  rdData  = bankOutA[b];
      if (rdBank2 == ADDR_W'(b)) rdData2 = bankOutB[b];
    end
  end

  always_ff @(posedge clk) begin
    if (strobes.clearAll) begin
      rdDataQ  <= '0;
      rdData2Q <= '0;
    end else begin
      rdDataQ  <= rdData;
      rdData2Q <= rdData2;
    end
  end

  // R7
  one_bank_chk: assert property (@(posedge clk) disable iff (strobes.clearAll)
    $onehot0(bankWe));
  // R9
  reg_lag_chk: assert property (@(posedge clk) disable iff (strobes.clearAll)
    1'b1 |=> rdDataQ == $past(rdData) && rdData2Q == $past(rdData2));
endmodule

// File: rtl/distRam.sv
module distRam
  import distRamPkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr2,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] rdData2,
  output logic [DATA_W-1:0] rdDataQ,
  output logic [DATA_W-1:0] rdData2Q
);
  ramStrobes_t strobes;

  distRamCtrl uCtrl (
    .rst(rst), .wrEn(wrEn), .strobes(strobes)
  );

  distRamDatapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uDp (
    .clk(clk), .strobes(strobes), .addr(addr), .rdAddr2(rdAddr2),
    .wrData(wrData), .rdData(rdData), .rdData2(rdData2),
    .rdDataQ(rdDataQ), .rdData2Q(rdData2Q)
  );
endmodule

// File: tb/sim_distRam.sv
`timescale 1ns/1ps
module sim_distRam;
  localparam int AW = 5;
  localparam int DW = 2;
  localparam int DEPTH = 1 << AW;

  logic clk = 0;
  logic rst = 1;
  logic wrEn = 0;
  logic [AW-1:0] addr = '0;
  logic [AW-1:0] rdAddr2 = '0;
  logic [DW-1:0] wrData = '0;
  logic [DW-1:0] rdData, rdData2, rdDataQ, rdData2Q;

  logic [DW-1:0] model [DEPTH];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  distRam #(.ADDR_W(AW), .DATA_W(DW)) u0 (
    .clk(clk), .rst(rst), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdAddr2(rdAddr2), .rdData(rdData), .rdData2(rdData2),
    .rdDataQ(rdDataQ), .rdData2Q(rdData2Q)
  );

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic doWrite(int a, logic [DW-1:0] d);
    @(negedge clk);
    addr = AW'(a); wrData = d; wrEn = 1;
    @(negedge clk);
    wrEn = 0;
    model[a] = d;
  endtask

  task automatic sweep(string req);
    for (int a = 0; a < DEPTH; a++) begin
      addr = AW'(a); rdAddr2 = AW'(DEPTH - 1 - a);
      #0.2;
      chk(req, rdData, model[a]);
      chk(req, rdData2, model[DEPTH - 1 - a]);
    end
  endtask

  task automatic tReset;
    for (int a = 0; a < DEPTH; a++) model[a] = '0;
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    #0.2;
    chk("R1 regA", rdDataQ, '0);
    chk("R1 regB", rdData2Q, '0);
    sweep("R1 sweep");
  endtask

  task automatic tWriteRead;
    doWrite(5, 2'b10);
    doWrite(12, 2'b01);
    doWrite(0, 2'b11);
    sweep("R2 R4 sweep");
  endtask

  task automatic tIgnore;
    @(negedge clk);
    addr = 5; wrData = 2'b01; wrEn = 0;
    @(negedge clk);
    #0.2;
    chk("R3 no write", rdData, 2'b10);
    sweep("R3 sweep");
  endtask

  task automatic tRdw;
    @(negedge clk);
    addr = 7; wrData = 2'b11; wrEn = 1;
    #0.2;
    chk("R5 before edge", rdData, model[7]);
    @(posedge clk);
    #0.2;
    chk("R5 after edge", rdData, 2'b11);
    @(negedge clk);
    wrEn = 0;
    model[7] = 2'b11;
  endtask

  task automatic tDual;
    @(negedge clk);
    rdAddr2 = 12; addr = 9; wrData = 2'b10; wrEn = 1;
    #0.2;
    chk("R6 other addr pre", rdData2, 2'b01);
    @(negedge clk);
    wrEn = 0; model[9] = 2'b10;
    chk("R6 other addr post", rdData2, 2'b01);
    rdAddr2 = 9; addr = 0;
    #0.2;
    chk("R6 independent", rdData2, 2'b10);
    chk("R4 primary", rdData, 2'b11);
  endtask

  task automatic tBanks;
    doWrite(3, 2'b01);
    doWrite(19, 2'b10);
    addr = 3; rdAddr2 = 19;
    #0.2;
    chk("R7 low bank", rdData, 2'b01);
    chk("R7 high bank", rdData2, 2'b10);
    doWrite(31, 2'b11);
    addr = 15;
    #0.2;
    chk("R7 alias", rdData, model[15]);
    sweep("R7 sweep");
  endtask

  task automatic tWidth;
    doWrite(20, 2'b01);
    addr = 20; #0.2;
    chk("R8 bit0 only", rdData, 2'b01);
    doWrite(20, 2'b10);
    addr = 20; #0.2;
    chk("R8 bit1 only", rdData, 2'b10);
  endtask

  task automatic tRegOut;
    @(negedge clk);
    addr = 19; rdAddr2 = 3;
    @(posedge clk);
    #0.2;
    chk("R9 regA", rdDataQ, model[19]);
    chk("R9 regB", rdData2Q, model[3]);
    addr = 31; rdAddr2 = 20;
    #0.2;
    chk("R9 regA holds", rdDataQ, model[19]);
    chk("R9 regB holds", rdData2Q, model[3]);
    @(posedge clk);
    #0.2;
    chk("R9 regA next", rdDataQ, model[31]);
    chk("R9 regB next", rdData2Q, model[20]);
  endtask

  task automatic finishRun;
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    tReset;
    tWriteRead;
    tIgnore;
    tRdw;
    tDual;
    tBanks;
    tWidth;
    tRegOut;
    tReset;
    finishRun;
  end

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    finishRun;
  end
endmodule